// File: doc/BRIEF.md
# Dual MIDI Byte Buffer with Packed Status

This block sits between a host register interface and two MIDI serial ports. Each port has a transmit byte FIFO, which the host fills with write strobes and which an external serializer drains, and a receive byte FIFO, which an external deserializer fills and the host empties with read strobes. The block does not generate bit timing. Its job is buffering, flow control, and reporting both ports' state in one status byte that the host polls.

On the line side, transmit bytes leave through a valid/ready stream. `tx_valid` is high whenever the transmit FIFO holds a byte, and `tx_data` shows the oldest byte. A byte is consumed on a clock edge where both `tx_valid` and `tx_ready` are high. While `tx_ready` is low, the byte and its valid stay where they are.

Receive bytes arrive on a valid/ready stream. A serial receiver cannot be stalled, so `rx_ready` stays high from the first clock after reset onward. Flow trouble is reported instead: a byte that arrives while the receive FIFO is full is dropped, and a sticky overflow flag is raised.

Top module: `midi_dual_buf`

## Requirements
- R1: A host write strobe `host_wr[i]` with a non-full transmit FIFO stores `host_wdata`. The stored bytes appear on `tx_data[8i+7:8i]` in write order. `tx_valid[i]` is high exactly when that FIFO is non-empty. While `tx_valid[i]` is high and `tx_ready[i]` is low, `tx_valid[i]` and `tx_data` hold their values.
- R2: A host write to a full transmit FIFO is discarded. The FIFO contents and order are unchanged.
- R3: Status bit 0 is high when the port 0 transmit FIFO holds DEPTH bytes. Status bit 1 is the same flag for port 1.
- R4: A byte with `rx_valid[i]` high, arriving at a non-full receive FIFO, is stored. A host read strobe `host_rd[i]` on a non-empty FIFO pops the oldest byte into `host_rx_data[8i+7:8i]`, visible from the clock edge that takes the strobe.
- R5: Status bit 3 (port 0) and status bit 5 (port 1) are high exactly when that receive FIFO is non-empty.
- R6: A byte arriving while the receive FIFO is full is dropped. The port's overflow flag is then set: status bit 2 for port 0, status bit 4 for port 1.
- R7: An overflow flag stays set until a host read pops a byte from that port. If a byte is dropped on the same edge as the read, the flag stays set.
- R8: A host read of an empty receive FIFO leaves `host_rx_data` unchanged and the FIFO empty.
- R9: After reset, the following are all zero: every status bit, `tx_valid`, and `host_rx_data`. Status bits 7 and 6 are always zero.
- R10: Traffic on one port does not change the other port's status bits or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 2 | Per-port transmit write strobe |
| host_wdata | input | 8 | Byte written by the host |
| host_rd | input | 2 | Per-port receive read strobe |
| host_rx_data | output | 16 | Last byte read from each port, port i in bits 8i+7..8i |
| status | output | 8 | Packed status byte |
| tx_valid | output | 2 | Transmit byte available per port |
| tx_data | output | 16 | Transmit byte per port |
| tx_ready | input | 2 | Serializer accepts the byte |
| rx_valid | input | 2 | Received byte offered per port |
| rx_data | input | 16 | Received byte per port |
| rx_ready | output | 2 | Receive stream accepts bytes (high after reset) |

## Verification
The hardest case to reach is a single clock edge on which a port's receive FIFO is exactly full, a new byte arrives, and the host reads. On that edge the drop and the clear compete for the overflow flag. The stimulus fills the FIFO with DEPTH bytes, then asserts `rx_valid` and `host_rd` in the same cycle. It then checks three things: the flag survived, the popped byte is the oldest one, and a further plain read clears the flag. Writing one byte beyond DEPTH into a transmit FIFO held back by a low `tx_ready` is the matching case on the transmit side. Draining that FIFO afterwards shows the extra byte never entered.

// File: rtl/midi_pkg.sv
package midi_pkg;
  localparam int NPORTS   = 2;
  localparam int BYTE_W   = 8;
  localparam int ST_FULL0 = 0;  // transmit full flags occupy bits 0..NPORTS-1
  localparam int ST_RXB   = 2;  // receive pair base: overflow at +2i, available at +2i+1
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/midi_byte_fifo.sv
module midi_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CFULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign full  = (cnt == CFULL);
  assign empty = (cnt == '0);
  assign head  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R2: the wrapping logic must never push into a full store
  p_push_room_r2: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  // R8: the wrapping logic must never pop an empty store
  p_pop_data_r8: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/midi_tx_lane.sv
module midi_tx_lane #(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  midi_pkg::byte_t   wdata,
  output logic              out_valid,
  output midi_pkg::byte_t   out_data,
  input  logic              out_ready,
  output logic              full
);
  logic empty, push, pop;

  assign push      = wr && !full;
  assign pop       = out_valid && out_ready;
  assign out_valid = !empty;

  midi_byte_fifo #(.DEPTH(DEPTH), .W(midi_pkg::BYTE_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(wdata), .pop(pop),
    .head(out_data), .full(full), .empty(empty)
  );

  // R1: an unaccepted byte stays offered and unchanged
  p_tx_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !full) |=> (out_valid && $stable(out_data)));
  // R2: a write into a full lane leaves it full when nothing drains
  p_tx_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && full && !out_ready) |=> full);
endmodule

// File: rtl/midi_rx_lane.sv
module midi_rx_lane #(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  midi_pkg::byte_t   in_data,
  input  logic              rd,
  output midi_pkg::byte_t   rd_data,
  output logic              avail,
  output logic              ovf
);
  logic full, empty, push, pop, drop;
  midi_pkg::byte_t head;

  assign push  = in_valid && !full;
  assign drop  = in_valid && full;
  assign pop   = rd && !empty;
  assign avail = !empty;

  midi_byte_fifo #(.DEPTH(DEPTH), .W(midi_pkg::BYTE_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(in_data), .pop(pop),
    .head(head), .full(full), .empty(empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      ovf     <= 1'b0;
    end else begin
      if (pop) rd_data <= head;
      if (drop)     ovf <= 1'b1;
      else if (pop) ovf <= 1'b0;
    end
  end

  p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full) |=> ovf);
  p_ovf_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && rd && avail && !(in_valid && full)) |=> !ovf);
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !rd) |=> ovf);
  p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !avail) |=> $stable(rd_data));
endmodule

// File: rtl/midi_dual_buf.sv
module midi_dual_buf #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  host_wr,
  input  logic [7:0]  host_wdata,
  input  logic [1:0]  host_rd,
  output logic [15:0] host_rx_data,
  output logic [7:0]  status,
  output logic [1:0]  tx_valid,
  output logic [15:0] tx_data,
  input  logic [1:0]  tx_ready,
  input  logic [1:0]  rx_valid,
  input  logic [15:0] rx_data,
  output logic [1:0]  rx_ready
);
  import midi_pkg::*;

  logic [NPORTS-1:0] tx_full, rx_avail, rx_ovf;
  logic              rdy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign rx_ready = {NPORTS{rdy_q}};

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    midi_tx_lane #(.DEPTH(DEPTH)) u_tx (
      .clk(clk), .rst_n(rst_n), .wr(host_wr[i]), .wdata(host_wdata),
      .out_valid(tx_valid[i]), .out_data(tx_data[i*BYTE_W +: BYTE_W]),
      .out_ready(tx_ready[i]), .full(tx_full[i])
    );
    midi_rx_lane #(.DEPTH(DEPTH)) u_rx (
      .clk(clk), .rst_n(rst_n), .in_valid(rx_valid[i] && rdy_q),
      .in_data(rx_data[i*BYTE_W +: BYTE_W]), .rd(host_rd[i]),
      .rd_data(host_rx_data[i*BYTE_W +: BYTE_W]),
      .avail(rx_avail[i]), .ovf(rx_ovf[i])
    );
  end

  always_comb begin
    status = '0;
    for (int i = 0; i < NPORTS; i++) begin
      status[ST_FULL0 + i]     = tx_full[i];
      status[ST_RXB + 2*i]     = rx_ovf[i];
      status[ST_RXB + 2*i + 1] = rx_avail[i];
    end
  end

  // R9: nothing is offered or flagged in the cycle after reset
  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_n |=> (tx_valid == '0 && status == '0));
  // R10: a read on one port does not change the other port's overflow flag
  p_port_isolate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd == 2'b01 && rx_valid == 2'b00) |=> $stable(rx_ovf[1]));
endmodule

// File: tb/tb_midi_dual_buf.sv
`timescale 1ns/1ps
module tb_midi_dual_buf;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  host_wr = '0, host_rd = '0, tx_ready = '0, rx_valid = '0;
  logic [7:0]  host_wdata = '0;
  logic [15:0] rx_data = '0;
  logic [15:0] host_rx_data, tx_data;
  logic [7:0]  status;
  logic [1:0]  tx_valid, rx_ready;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  midi_dual_buf #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rx_data(host_rx_data), .status(status),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready)
  );

  // {is_read, port, byte, expected status afterwards}
  localparam logic [17:0] VEC [8] = '{
    {1'b0, 1'b0, 8'h90, 8'h08},
    {1'b0, 1'b1, 8'h3C, 8'h28},
    {1'b0, 1'b0, 8'h45, 8'h28},
    {1'b1, 1'b0, 8'h90, 8'h28},
    {1'b1, 1'b1, 8'h3C, 8'h08},
    {1'b1, 1'b0, 8'h45, 8'h00},
    {1'b0, 1'b1, 8'h11, 8'h20},
    {1'b1, 1'b1, 8'h11, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rx_put(input int p, input logic [7:0] d);
    rx_valid[p] = 1'b1; rx_data[p*8 +: 8] = d;
    @(negedge clk);
    rx_valid[p] = 1'b0;
  endtask

  task automatic host_read(input int p);
    host_rd[p] = 1'b1;
    @(negedge clk);
    host_rd[p] = 1'b0;
  endtask

  task automatic host_write(input int p, input logic [7:0] d);
    host_wr[p] = 1'b1; host_wdata = d;
    @(negedge clk);
    host_wr[p] = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 status in reset", {24'h0, status}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset status", {24'h0, status}, 32'h0);
    chk("R9 reset tx_valid", {30'h0, tx_valid}, 32'h0);
    chk("R9 reset rx data", {16'h0, host_rx_data}, 32'h0);
    chk("R4 rx_ready after reset", {30'h0, rx_ready}, 32'h3);

    // Table walk: R4 R5 R10
    foreach (VEC[k]) begin
      if (VEC[k][17]) begin
        host_read(int'(VEC[k][16]));
        chk("R4 read data", {24'h0, host_rx_data[VEC[k][16]*8 +: 8]}, {24'h0, VEC[k][15:8]});
      end else begin
        rx_put(int'(VEC[k][16]), VEC[k][15:8]);
      end
      chk("R5 R10 status", {24'h0, status}, {24'h0, VEC[k][7:0]});
    end

    // R8: read of empty port 0 keeps the last byte
    host_read(0);
    chk("R8 empty read data", {24'h0, host_rx_data[7:0]}, 32'h45);
    chk("R8 empty read status", {24'h0, status}, 32'h0);

    // R1: held byte while not ready, then ordered drain
    host_write(0, 8'hA1); host_write(0, 8'hB2); host_write(0, 8'hC3);
    chk("R1 tx_valid", {30'h0, tx_valid}, 32'h1);
    chk("R1 head held", {24'h0, tx_data[7:0]}, 32'hA1);
    @(negedge clk);
    chk("R1 head still held", {24'h0, tx_data[7:0]}, 32'hA1);
    tx_ready[0] = 1'b1;
    for (int j = 0; j < 3; j++) begin
      chk("R1 drain order", {24'h0, tx_data[7:0]}, 32'hA1 + 32'h11 * j);
      @(negedge clk);
    end
    tx_ready[0] = 1'b0;
    chk("R1 empty after drain", {30'h0, tx_valid}, 32'h0);

    // R2 R3: fill port 1 transmit, extra write discarded
    for (int j = 0; j < DEPTH; j++) host_write(1, 8'(j + 8'h20));
    chk("R3 port1 full flag", {24'h0, status}, 32'h02);
    host_write(1, 8'hEE);
    chk("R3 still full", {24'h0, status}, 32'h02);
    tx_ready[1] = 1'b1;
    for (int j = 0; j < DEPTH; j++) begin
      chk("R2 drain value", {24'h0, tx_data[15:8]}, 32'(j + 8'h20));
      @(negedge clk);
    end
    tx_ready[1] = 1'b0;
    chk("R2 no extra byte", {30'h0, tx_valid}, 32'h0);

    // R3 port 0
    for (int j = 0; j < DEPTH; j++) host_write(0, 8'(j));
    chk("R3 port0 full flag", {24'h0, status}, 32'h01);
    tx_ready[0] = 1'b1;
    repeat (DEPTH) @(negedge clk);
    tx_ready[0] = 1'b0;
    chk("R3 port0 drained", {24'h0, status}, 32'h0);

    // R6 R7: overflow on port 0
    for (int j = 0; j < DEPTH; j++) rx_put(0, 8'(j + 8'h50));
    chk("R5 full rx avail", {24'h0, status}, 32'h08);
    rx_put(0, 8'hFF);
    chk("R6 overflow set", {24'h0, status}, 32'h0C);
    @(negedge clk);
    chk("R7 overflow sticky", {24'h0, status}, 32'h0C);
    host_read(0);
    chk("R7 overflow cleared", {24'h0, status}, 32'h08);
    chk("R7 read oldest", {24'h0, host_rx_data[7:0]}, 32'h50);
    for (int j = 1; j < DEPTH; j++) begin
      host_read(0);
      chk("R6 drop kept order", {24'h0, host_rx_data[7:0]}, 32'(j + 8'h50));
    end
    chk("R6 dropped byte absent", {24'h0, status}, 32'h0);

    // R7 corner: drop and read on the same edge
    for (int j = 0; j < DEPTH; j++) rx_put(1, 8'(j + 8'h70));
    rx_valid[1] = 1'b1; rx_data[15:8] = 8'hDD; host_rd[1] = 1'b1;
    @(negedge clk);
    rx_valid[1] = 1'b0; host_rd[1] = 1'b0;
    chk("R7 same-edge overflow held", {24'h0, status}, 32'h30);
    chk("R7 same-edge read data", {24'h0, host_rx_data[15:8]}, 32'h70);
    chk("R10 port0 untouched", {24'h0, host_rx_data[7:0]}, 32'h5F);
    host_read(1);
    chk("R7 later read clears", {24'h0, status}, 32'h20);
    chk("R9 spare bits zero", {30'h0, status[7:6]}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule